// File: doc/BRIEF.md
# Burst Memory Byte-Write and Bus Direction Control

This block sits between the address generator of a flow-through synchronous burst memory and its storage array. On every rising clock edge it classifies the new cycle as a read, a write or a deselect. The classification uses the start strobes, the chip-select qualification and the write controls sampled at that edge. For a write it turns the write controls into one write strobe per byte lane and stores the input data word into a byte-masked array on the same edge. For a read it presents the word at the registered address on the output side of the common data bus in the same cycle, with no extra pipeline stage.

There are two start strobes. A start from the processor strobe is always a read. A start from the controller strobe can be a read or a write. Cycles after either start continue the open burst, and any of them can be a write. The tri-state enable of the data bus is the only output-side control. It rises only for a read cycle with output enable low. Output enable acts at once, without waiting for a clock edge. A write cycle, including a partial one, forces the drive off.

Top module: `bwc_top`

## Requirements
- R1: When `all_wr_n` is low in a write-capable cycle, all four byte lanes are written with the input word, whatever `lane_wr_en_n` and `lane_sel_n` hold.
- R2: With `all_wr_n` high and `lane_wr_en_n` low, lane n (bits 8n+7 down to 8n of the word) is written exactly when `lane_sel_n[n]` is low. The other lanes keep their old contents.
- R3: With `all_wr_n` high, a cycle is a read when `lane_wr_en_n` is high, or when `lane_wr_en_n` is low and all four `lane_sel_n` bits are high. Such a cycle writes nothing.
- R4: A cycle started with `chip_sel` high and `proc_start_n` low is a read. Its write controls are ignored and nothing is stored.
- R5: A cycle started with `chip_sel` high, `ctrl_start_n` low and `proc_start_n` high is a write when the write controls request one, and a read otherwise.
- R6: A cycle with both strobes high, following an active (read or write) cycle, continues the burst at the presented address. It is a write or a read according to its own write controls.
- R7: During a read cycle, `dq_o` carries the stored word at the address registered on the latest rising edge, within that same cycle.
- R8: `dq_oe` is high only in a read cycle while `out_en_n` is low. A change of `out_en_n` reaches `dq_oe` without waiting for a clock edge.
- R9: `dq_oe` is low in every write cycle, full or partial, whatever the level of `out_en_n`.
- R10: A strobe sampled with `chip_sel` low deselects the block. Cycles with no strobe after a deselect stay deselected. A deselected cycle stores nothing and does not drive the bus.
- R11: After reset, and before any qualified start, the block is deselected and `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chip_sel | input | 1 | All chip-enable qualifications true, sampled with the strobes |
| proc_start_n | input | 1 | Processor start strobe, active low |
| ctrl_start_n | input | 1 | Controller start strobe, active low |
| burst_addr | input | AW (6) | Word address from the address generator for the cycle being started |
| all_wr_n | input | 1 | Whole-word write, active low, overrides lane controls |
| lane_wr_en_n | input | 1 | Lane write enable, active low |
| lane_sel_n | input | LANES (4) | Per-lane write select, active low, bit n for lane n |
| wr_data | input | DW (32) | Input side of the data bus |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| dq_o | output | DW (32) | Output side of the data bus, zero when not driven |
| dq_oe | output | 1 | Tri-state enable for the data bus |

## Verification
The decode is tried with whole-word writes that carry conflicting lane controls, with scattered lane masks, and with the two lane patterns that must fall back to a read. Comparing the stored words tells a true override apart from a mask merge. Each write pattern is then repeated under a processor-strobe start, a controller-strobe start, burst continuation and deselect. Each of these must store or refuse the same word for a different reason, so a wrong gating of the write controls shows up as a changed shadow word. A long random phase mixes all of these patterns. Output-enable toggles inside a cycle separate the asynchronous path from any clocked one.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_kind_t;
endpackage

// File: rtl/bwc_cycle_decode.sv
module bwc_cycle_decode
  import bwc_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             chip_sel,
  input  logic             proc_start_n,
  input  logic             ctrl_start_n,
  input  logic             all_wr_n,
  input  logic             lane_wr_en_n,
  input  logic [LANES-1:0] lane_sel_n,
  input  cyc_kind_t        cur_kind,
  output cyc_kind_t        nxt_kind,
  output logic [LANES-1:0] wr_strb,
  output logic             wr_window,
  output logic             load_addr
);
  // Requested lanes from the write controls alone.
  function automatic logic [LANES-1:0] lane_mask(input logic g_n,
                                                 input logic e_n,
                                                 input logic [LANES-1:0] s_n);
    if (!g_n)      return '1;
    else if (!e_n) return ~s_n;
    else           return '0;
  endfunction

  logic any_strobe, proc_go, ctrl_go, cont_go;
  logic [LANES-1:0] req_mask;

  always_comb begin
    any_strobe = !proc_start_n || !ctrl_start_n;
    proc_go    = any_strobe && chip_sel && !proc_start_n;
    ctrl_go    = any_strobe && chip_sel && proc_start_n;
    cont_go    = !any_strobe && (cur_kind != CYC_IDLE);
    req_mask   = lane_mask(all_wr_n, lane_wr_en_n, lane_sel_n);
    wr_window  = ctrl_go || cont_go;
    wr_strb    = wr_window ? req_mask : '0;
    load_addr  = proc_go || ctrl_go || cont_go;
    if (proc_go)            nxt_kind = CYC_READ;
    else if (wr_window)     nxt_kind = (|wr_strb) ? CYC_WRITE : CYC_READ;
    else                    nxt_kind = CYC_IDLE;
  end
endmodule

// File: rtl/bwc_byte_array.sv
module bwc_byte_array #(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 8,
  localparam int DEPTH = 1 << AW,
  localparam int DW    = LANES * LW
) (
  input  logic             clk,
  input  logic [LANES-1:0] we,
  input  logic [AW-1:0]    waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [AW-1:0]    raddr,
  output logic [DW-1:0]    rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] bank [DEPTH];
    always_ff @(posedge clk) begin
      if (we[g]) bank[waddr] <= wdata[g*LW +: LW];
    end
    assign rdata[g*LW +: LW] = bank[raddr];
  end
endmodule

// File: rtl/bwc_bus_drive.sv
module bwc_bus_drive
  import bwc_pkg::*;
#(
  parameter int DW = 32
) (
  input  cyc_kind_t     kind,
  input  logic          out_en_n,
  input  logic [DW-1:0] rword,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe
);
  always_comb begin
    dq_oe = (kind == CYC_READ) && !out_en_n;
    dq_o  = dq_oe ? rword : '0;
  end
endmodule

// File: rtl/bwc_top.sv
module bwc_top
  import bwc_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 8,
  localparam int DW   = LANES * LW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chip_sel,
  input  logic             proc_start_n,
  input  logic             ctrl_start_n,
  input  logic [AW-1:0]    burst_addr,
  input  logic             all_wr_n,
  input  logic             lane_wr_en_n,
  input  logic [LANES-1:0] lane_sel_n,
  input  logic [DW-1:0]    wr_data,
  input  logic             out_en_n,
  output logic [DW-1:0]    dq_o,
  output logic             dq_oe
);
  cyc_kind_t        kind_q, kind_d;
  logic [AW-1:0]    addr_q;
  logic [LANES-1:0] wr_strb;
  logic             wr_window, load_addr;
  logic [DW-1:0]    rword;

  bwc_cycle_decode #(.LANES(LANES)) u_dec (
    .chip_sel     (chip_sel),
    .proc_start_n (proc_start_n),
    .ctrl_start_n (ctrl_start_n),
    .all_wr_n     (all_wr_n),
    .lane_wr_en_n (lane_wr_en_n),
    .lane_sel_n   (lane_sel_n),
    .cur_kind     (kind_q),
    .nxt_kind     (kind_d),
    .wr_strb      (wr_strb),
    .wr_window    (wr_window),
    .load_addr    (load_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= CYC_IDLE;
      addr_q <= '0;
    end else begin
      kind_q <= kind_d;
      if (load_addr) addr_q <= burst_addr;
    end
  end

  bwc_byte_array #(.AW(AW), .LANES(LANES), .LW(LW)) u_arr (
    .clk   (clk),
    .we    (wr_strb),
    .waddr (burst_addr),
    .wdata (wr_data),
    .raddr (addr_q),
    .rdata (rword)
  );

  bwc_bus_drive #(.DW(DW)) u_bus (
    .kind     (kind_q),
    .out_en_n (out_en_n),
    .rword    (rword),
    .dq_o     (dq_o),
    .dq_oe    (dq_oe)
  );
endmodule

// File: rtl/bwc_checker.sv
module bwc_checker
  import bwc_pkg::*;
#(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chip_sel,
  input logic             proc_start_n,
  input logic             ctrl_start_n,
  input logic             all_wr_n,
  input logic             out_en_n,
  input logic             wr_window,
  input logic [LANES-1:0] wr_strb,
  input cyc_kind_t        kind_q,
  input logic             dq_oe
);
  assert_all_lanes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_window && !all_wr_n) |-> (wr_strb == '1));

  assert_proc_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_sel && !proc_start_n) |-> (wr_strb == '0));

  assert_proc_kind_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_sel && !proc_start_n) |=> (kind_q == CYC_READ));

  assert_oe_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !dq_oe);

  assert_write_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == CYC_WRITE) |-> !dq_oe);

  assert_deselect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_sel && (!proc_start_n || !ctrl_start_n)) |-> (wr_strb == '0));

  assert_deselect_hiz_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_sel && (!proc_start_n || !ctrl_start_n)) |=> !dq_oe);
endmodule

bind bwc_top bwc_checker #(.LANES(LANES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .chip_sel     (chip_sel),
  .proc_start_n (proc_start_n),
  .ctrl_start_n (ctrl_start_n),
  .all_wr_n     (all_wr_n),
  .out_en_n     (out_en_n),
  .wr_window    (wr_window),
  .wr_strb      (wr_strb),
  .kind_q       (kind_q),
  .dq_oe        (dq_oe)
);

// File: tb/bwc_top_tb.sv
module bwc_top_tb;
  localparam int AW = 6;
  localparam int LANES = 4;
  localparam int DW = 32;
  localparam int NWORDS = 1 << AW;

  logic clk = 0;
  logic rst_n = 0;
  logic chip_sel = 0, proc_start_n = 1, ctrl_start_n = 1;
  logic [AW-1:0] burst_addr = '0;
  logic all_wr_n = 1, lane_wr_en_n = 1;
  logic [LANES-1:0] lane_sel_n = '1;
  logic [DW-1:0] wr_data = '0;
  logic out_en_n = 1;
  logic [DW-1:0] dq_o;
  logic dq_oe;

  always #10 clk = ~clk;

  bwc_top u_dut (
    .clk(clk), .rst_n(rst_n), .chip_sel(chip_sel),
    .proc_start_n(proc_start_n), .ctrl_start_n(ctrl_start_n),
    .burst_addr(burst_addr), .all_wr_n(all_wr_n),
    .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n),
    .wr_data(wr_data), .out_en_n(out_en_n), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  // Behavioural reference: 0 idle, 1 read, 2 write
  int unsigned shadow [NWORDS];
  int m_kind = 0;
  int m_addr = 0;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_bus(input string tag);
    bit exp_oe;
    exp_oe = (m_kind == 1) && !out_en_n;
    check(dq_oe == exp_oe, tag, dq_oe, exp_oe);
    if (exp_oe) check(dq_o == shadow[m_addr], tag, dq_o, shadow[m_addr]);
  endtask

  task automatic cyc(input bit sel, input bit p_n, input bit c_n, input int a,
                     input bit g_n, input bit e_n, input bit [3:0] s_n,
                     input int unsigned d, input bit oe_n, input string tag);
    bit strobe, may_write;
    int unsigned lanes;
    @(negedge clk);
    chip_sel = sel; proc_start_n = p_n; ctrl_start_n = c_n;
    burst_addr = a[AW-1:0]; all_wr_n = g_n; lane_wr_en_n = e_n;
    lane_sel_n = s_n; wr_data = d; out_en_n = oe_n;
    strobe = !p_n || !c_n;
    lanes = 0;
    for (int i = 0; i < LANES; i++)
      if (!g_n || (!e_n && !s_n[i])) lanes |= 32'hFF << (8 * i);
    if (strobe && !sel) m_kind = 0;
    else if (strobe && !p_n) begin m_kind = 1; m_addr = a; end
    else if (strobe || m_kind != 0) begin
      m_addr = a;
      if (lanes != 0) begin
        m_kind = 2;
        shadow[a] = (shadow[a] & ~lanes) | (d & lanes);
      end else m_kind = 1;
    end
    @(posedge clk);
    #5;
    compare_bus(tag);
  endtask

  // read back a word with a processor-strobe start
  task automatic rd(input int a, input string tag);
    cyc(1, 0, 1, a, 1, 1, 4'hF, 0, 0, tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    check(dq_oe == 0, "R11 reset bus off", dq_oe, 0);
    rst_n = 1;
    cyc(0, 1, 1, 0, 1, 1, 4'hF, 0, 0, "R11 idle after reset");

    // preload every word with a whole-word controller write (R1, R5)
    for (int i = 0; i < NWORDS; i++)
      cyc(1, 1, 0, i, 0, 1, 4'hF, 32'h1000_0000 + i * 32'h0101, 0, "R5 preload write hiz R9");

    cyc(1, 1, 0, 5, 0, 0, 4'h5, 32'hA1B2_C3D4, 0, "R1 global overrides lanes");
    rd(5, "R1 readback");
    cyc(1, 1, 0, 5, 1, 0, 4'hA, 32'h1122_3344, 0, "R2 lanes 0 and 2 write hiz R9");
    rd(5, "R2 merged readback R7");
    cyc(1, 1, 0, 9, 1, 0, 4'h7, 32'hDEAD_BEEF, 1, "R2 lane 3 write");
    rd(9, "R2 lane 3 readback");

    cyc(1, 0, 1, 5, 0, 0, 4'h0, 32'h5555_5555, 0, "R4 proc start ignores writes");
    rd(5, "R4 word unchanged");
    cyc(1, 0, 0, 7, 0, 1, 4'hF, 32'h6666_6666, 0, "R4 proc wins over ctrl");
    rd(7, "R4 word unchanged 2");

    cyc(1, 1, 0, 12, 1, 1, 4'h0, 32'h7777_7777, 0, "R3 lane enable high reads");
    cyc(1, 1, 0, 12, 1, 0, 4'hF, 32'h7777_7777, 0, "R3 no lanes reads");
    rd(12, "R3 word unchanged");

    // burst continuation
    cyc(1, 0, 1, 20, 1, 1, 4'hF, 0, 0, "R7 start burst read");
    cyc(1, 1, 1, 21, 1, 0, 4'hE, 32'h0000_00AB, 0, "R6 continue write lane 0");
    cyc(1, 1, 1, 22, 1, 1, 4'hF, 0, 0, "R6 continue read");
    cyc(1, 1, 1, 22, 0, 1, 4'hF, 32'hCAFE_F00D, 0, "R6 continue write full");
    rd(21, "R6 lane 0 readback");
    rd(22, "R6 full readback");

    // async output enable
    rd(3, "R8 read driven");
    #2 out_en_n = 1; #1;
    check(dq_oe == 0, "R8 async disable", dq_oe, 0);
    #2 out_en_n = 0; #1;
    check(dq_oe == 1 && dq_o == shadow[3], "R8 async enable", dq_o, shadow[3]);
    cyc(1, 1, 0, 4, 0, 1, 4'hF, 32'h0BAD_0BAD, 0, "R9 write with oe low");

    // deselect
    cyc(0, 1, 0, 30, 0, 1, 4'hF, 32'hFFFF_0000, 0, "R10 deselect hiz");
    cyc(1, 1, 1, 31, 0, 1, 4'hF, 32'hFFFF_1111, 0, "R10 stays deselected");
    rd(30, "R10 no write at 30");
    rd(31, "R10 no write at 31");

    // random phase
    for (int k = 0; k < 3000; k++) begin
      int unsigned r;
      r = $urandom;
      cyc((r[3:0] != 0), r[4], r[5], int'(r[11:6]), (r[14:12] != 0), r[15],
          r[19:16], $urandom, (r[22:20] == 0), "R7 random");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule